// File: doc/BRIEF.md
# Serial Command Front End for a 12-bit DAC

This block is the digital front end of a 12-bit voltage-output converter. A host sends 16-bit words over a three-wire link made of an active-low select, a serial clock and a data line. Each word holds a 4-bit command followed by 12 data bits, and the block uses them to move codes between a serial shift register, a staging (input) register and the output (DAC) register that drives the converter code. Two side inputs act outside the serial link. An active-low load strobe copies the staging register into the output register. An active-low clear drives both registers to zero code. A pair of commands raises and lowers a power-down flag.

All pins are sampled by a fast system clock through two-stage synchronizers, and a three-state frame machine tracks each word. The states are IDLE (select high), SHIFT (select low, bits being counted) and SPOILED (select low, but a load strobe edge or an active clear was seen). The transitions are:
- IDLE to SHIFT on a select fall.
- IDLE to SPOILED on a select fall that coincides with load or clear activity.
- SHIFT to SPOILED on load or clear activity.
- SHIFT to IDLE on a select rise. The word commits if exactly 16 bits arrived and no corruption occurred; otherwise it is discarded.
- SPOILED to IDLE on a select rise, discarding the word.

A sticky error flag records discarded words.

Top module: `dac_cmd_front`

## Requirements
- R1: A word is 16 bits, first bit received is the most significant: bits 15..12 are the command, bits 11..0 the data. A word is acted on only at the rising edge of the select.
- R2: Command 4'b0001 writes the data into the staging register and leaves the output code unchanged.
- R3: Command 4'b0010 writes the data into both the staging and the output registers.
- R4: Command 4'b0100 copies the staging register into the output register; its data bits are ignored and the staging register keeps its value.
- R5: Command 4'b0110 sets the power-down flag and command 4'b1000 clears it. Neither changes either register.
- R6: Command 4'b0000 and every code not listed in R2 to R5 change no register and no flag other than clearing the error flag.
- R7: A falling edge on the active-low load input copies the staging register into the output register, once per edge.
- R8: While the active-low clear input is low, both registers are held at zero. The power-down flag is not affected.
- R9: A word with a bit count other than 16 at the select rise is discarded and sets the error flag.
- R10: A load edge or an active clear seen while the select is low spoils the word. The word is discarded and the error flag is set, while the load or clear itself still takes effect.
- R11: The error flag stays set until the next word that is committed, whatever its command.
- R12: Any pin change shows at the outputs on the fourth rising clock edge that samples the new pin level.
- R13: After reset the output code is zero, power-down is clear and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, must run well above the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low word select |
| sclk | input | 1 | Serial bit clock, data taken on its rising edge |
| din | input | 1 | Serial data, most significant bit first |
| ldac_n | input | 1 | Active-low load strobe, acts on its falling edge |
| clr_n | input | 1 | Active-low clear, level sensitive |
| dac_code | output | 12 | Output register contents driving the converter |
| shutdown | output | 1 | Power-down flag |
| frame_err | output | 1 | Sticky flag for discarded words |

## Verification
Most internal faults reach the ports within three clocks of the pin event that exposes them. A bit counter off by one makes every good word raise the error flag at its select rise. A misordered shift register lands a wrong code on the output as soon as a both-register load commits. A wrong staging value is invisible until a copy command or a load strobe moves it out, so every staging write in the bench is later followed by one of those, and every discarded or reserved word is followed by a copy that proves the staging register was untouched. The bench carries its own pin-level model, delayed by the synchronizer depth, and compares all three outputs on every clock, so a one-cycle latency error also shows.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP       = 4'b0000,
        CMD_LOAD_STG  = 4'b0001,
        CMD_LOAD_BOTH = 4'b0010,
        CMD_COPY      = 4'b0100,
        CMD_PWR_DOWN  = 4'b0110,
        CMD_PWR_UP    = 4'b1000
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_SPOILED
    } frame_state_e;

    // pin vector positions inside the synchronizer bank
    localparam int PIN_CS   = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_DIN  = 2;
    localparam int PIN_LDAC = 3;
    localparam int PIN_CLR  = 4;
    localparam int PIN_N    = 5;

endpackage

// File: rtl/dac_cmd_sync.sv
module dac_cmd_sync #(
    parameter int         N       = 5,
    parameter int         STAGES  = 2,
    parameter logic [N-1:0] IDLE_V = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);

    genvar b;
    generate
        for (b = 0; b < N; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            logic              prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{IDLE_V[b]}};
                    prev_q  <= IDLE_V[b];
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
                    prev_q  <= chain_q[STAGES-1];
                end
            end

            assign lvl_o[b]  = chain_q[STAGES-1];
            assign prev_o[b] = prev_q;
        end
    endgenerate

endmodule

// File: rtl/dac_cmd_frame.sv
module dac_cmd_frame
    import dac_cmd_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_lvl,
    input  logic               cs_prev,
    input  logic               sclk_lvl,
    input  logic               sclk_prev,
    input  logic               din_lvl,
    input  logic               ldac_lvl,
    input  logic               ldac_prev,
    input  logic               clr_lvl,
    output logic               commit_o,
    output logic               bad_o,
    output logic               ldac_o,
    output logic               clr_o,
    output logic [FRAME_W-1:0] word_o
);

    localparam int               CNT_W    = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    frame_state_e        state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [FRAME_W-1:0]  shreg_q;

    logic cs_fall, cs_rise, sclk_rise, ldac_fall, corrupt;

    assign cs_fall   =  cs_prev   & ~cs_lvl;
    assign cs_rise   = ~cs_prev   &  cs_lvl;
    assign sclk_rise = ~sclk_prev &  sclk_lvl;
    assign ldac_fall =  ldac_prev & ~ldac_lvl;
    assign corrupt   =  ldac_fall | ~clr_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = corrupt ? ST_SPOILED : ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_rise)      state_d = ST_IDLE;
                else if (corrupt) state_d = ST_SPOILED;
            end
            ST_SPOILED: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shreg_q  <= '0;
            word_o   <= '0;
            commit_o <= 1'b0;
            bad_o    <= 1'b0;
            ldac_o   <= 1'b0;
            clr_o    <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            bad_o    <= 1'b0;
            ldac_o   <= ldac_fall;
            clr_o    <= ~clr_lvl;
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) begin
                        cnt_q   <= '0;
                        shreg_q <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        if (corrupt || (cnt_q != CNT_FULL)) begin
                            bad_o <= 1'b1;
                        end else begin
                            commit_o <= 1'b1;
                            word_o   <= shreg_q;
                        end
                    end else if (!corrupt && sclk_rise) begin
                        shreg_q <= {shreg_q[FRAME_W-2:0], din_lvl};
                        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SPOILED: begin
                    if (cs_rise) bad_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
    import dac_cmd_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              bad_i,
    input  logic              ldac_i,
    input  logic              clr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] stage_o,
    output logic [DATA_W-1:0] dac_o,
    output logic              pd_o,
    output logic              err_o
);

    cmd_e cmd;
    assign cmd = cmd_e'(cmd_i);

    // code registers: clear wins, then a committed word, then the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_o <= '0;
            dac_o   <= '0;
        end else if (clr_i) begin
            stage_o <= '0;
            dac_o   <= '0;
        end else if (commit_i) begin
            unique case (cmd)
                CMD_LOAD_STG:  stage_o <= data_i;
                CMD_LOAD_BOTH: begin
                    stage_o <= data_i;
                    dac_o   <= data_i;
                end
                CMD_COPY:      dac_o <= stage_o;
                default: ;
            endcase
        end else if (ldac_i) begin
            dac_o <= stage_o;
        end
    end

    // power-down and error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_o  <= 1'b0;
            err_o <= 1'b0;
        end else begin
            if (bad_i)         err_o <= 1'b1;
            else if (commit_i) err_o <= 1'b0;
            if (commit_i) begin
                unique case (cmd)
                    CMD_PWR_DOWN: pd_o <= 1'b1;
                    CMD_PWR_UP:   pd_o <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dac_cmd_front.sv
module dac_cmd_front
    import dac_cmd_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic [DATA_W-1:0] dac_code,
    output logic              shutdown,
    output logic              frame_err
);

    localparam int               FRAME_W = CMD_W + DATA_W;
    localparam logic [PIN_N-1:0] IDLE_V  = 5'b11001;

    logic [PIN_N-1:0]   pin_v, lvl_v, prev_v;
    logic               commit_s, bad_s, ldac_s, clr_s;
    logic [FRAME_W-1:0] word_s;
    logic [DATA_W-1:0]  stage_reg;
    logic               unused_prev;

    assign pin_v[PIN_CS]   = cs_n;
    assign pin_v[PIN_SCLK] = sclk;
    assign pin_v[PIN_DIN]  = din;
    assign pin_v[PIN_LDAC] = ldac_n;
    assign pin_v[PIN_CLR]  = clr_n;
    assign unused_prev     = prev_v[PIN_DIN] ^ prev_v[PIN_CLR];

    dac_cmd_sync #(
        .N      (PIN_N),
        .STAGES (SYNC_STAGES),
        .IDLE_V (IDLE_V)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_v),
        .lvl_o  (lvl_v),
        .prev_o (prev_v)
    );

    dac_cmd_frame #(
        .FRAME_W (FRAME_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (lvl_v[PIN_CS]),
        .cs_prev   (prev_v[PIN_CS]),
        .sclk_lvl  (lvl_v[PIN_SCLK]),
        .sclk_prev (prev_v[PIN_SCLK]),
        .din_lvl   (lvl_v[PIN_DIN]),
        .ldac_lvl  (lvl_v[PIN_LDAC]),
        .ldac_prev (prev_v[PIN_LDAC]),
        .clr_lvl   (lvl_v[PIN_CLR]),
        .commit_o  (commit_s),
        .bad_o     (bad_s),
        .ldac_o    (ldac_s),
        .clr_o     (clr_s),
        .word_o    (word_s)
    );

    dac_cmd_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_s),
        .bad_i    (bad_s),
        .ldac_i   (ldac_s),
        .clr_i    (clr_s),
        .cmd_i    (word_s[FRAME_W-1 -: CMD_W]),
        .data_i   (word_s[DATA_W-1:0]),
        .stage_o  (stage_reg),
        .dac_o    (dac_code),
        .pd_o     (shutdown),
        .err_o    (frame_err)
    );

endmodule

// File: rtl/dac_cmd_checker.sv
module dac_cmd_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              bad,
    input logic              ldac_act,
    input logic              clr_act,
    input logic [DATA_W-1:0] stage,
    input logic [DATA_W-1:0] dac_code,
    input logic              shutdown,
    input logic              frame_err
);

    assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (dac_code == '0) && (stage == '0));

    assert_strobe_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_act && !clr_act && !commit) |=> (dac_code == $past(stage)));

    assert_clear_spoils_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && clr_act));

    assert_commit_or_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && bad));

    assert_err_set_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $past(bad));

    assert_err_clear_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_err) |-> $past(commit));

    assert_pd_by_command_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shutdown) |-> $past(commit));

    assert_code_change_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(commit || ldac_act || clr_act));

endmodule

bind dac_cmd_front dac_cmd_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_s),
    .bad       (bad_s),
    .ldac_act  (ldac_s),
    .clr_act   (clr_s),
    .stage     (stage_reg),
    .dac_code  (dac_code),
    .shutdown  (shutdown),
    .frame_err (frame_err)
);

// File: tb/tb_dac_cmd_front.sv
`timescale 1ns/1ps
module tb_dac_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic [11:0] dac_code;
    logic        shutdown, frame_err;

    always #2.5 clk = ~clk;

    dac_cmd_front dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .ldac_n(ldac_n), .clr_n(clr_n),
        .dac_code(dac_code), .shutdown(shutdown), .frame_err(frame_err)
    );

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R13";
    bit    done    = 1'b0;

    // behavioural model: pins seen three samples late, {clr,ldac,din,sclk,cs}
    logic [4:0]  hist [0:4];
    int          m_state, m_cnt;
    logic [15:0] m_bits;
    logic [11:0] m_stg, m_dac;
    logic        m_pd, m_err;

    task automatic model_step(input logic [4:0] c, input logic [4:0] p);
        logic csf, csr, skr, ldf, cor, cm, bd;
        csf = p[0] & ~c[0];
        csr = ~p[0] & c[0];
        skr = ~p[1] & c[1];
        ldf = p[3] & ~c[3];
        cor = ldf | ~c[4];
        cm  = 1'b0;
        bd  = 1'b0;
        if (m_state == 0) begin
            if (csf) begin
                m_state = cor ? 2 : 1;
                m_cnt   = 0;
                m_bits  = 16'h0;
            end
        end else if (m_state == 1) begin
            if (csr) begin
                m_state = 0;
                if (cor || m_cnt != 16) bd = 1'b1;
                else                    cm = 1'b1;
            end else if (cor) begin
                m_state = 2;
            end else if (skr) begin
                m_bits = {m_bits[14:0], c[2]};
                if (m_cnt < 17) m_cnt++;
            end
        end else begin
            if (csr) begin
                m_state = 0;
                bd      = 1'b1;
            end
        end
        if (!c[4]) begin
            m_stg = 12'h0;
            m_dac = 12'h0;
        end else if (cm) begin
            case (m_bits[15:12])
                4'd1: m_stg = m_bits[11:0];
                4'd2: begin m_stg = m_bits[11:0]; m_dac = m_bits[11:0]; end
                4'd4: m_dac = m_stg;
                default: ;
            endcase
        end else if (ldf) begin
            m_dac = m_stg;
        end
        if (cm && m_bits[15:12] == 4'd6) m_pd = 1'b1;
        if (cm && m_bits[15:12] == 4'd8) m_pd = 1'b0;
        if (bd)      m_err = 1'b1;
        else if (cm) m_err = 1'b0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) hist[i] = 5'b11001;
            m_state = 0; m_cnt = 0; m_bits = 16'h0;
            m_stg = 12'h0; m_dac = 12'h0; m_pd = 1'b0; m_err = 1'b0;
        end else begin
            for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = {clr_n, ldac_n, din, sclk, cs_n};
            model_step(hist[3], hist[4]);
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (dac_code !== m_dac || shutdown !== m_pd || frame_err !== m_err) begin
                errors++;
                $display("FAIL %s model: dac=%h pd=%b err=%b expected dac=%h pd=%b err=%b",
                         cur_req, dac_code, shutdown, frame_err, m_dac, m_pd, m_err);
            end
        end
    end

    task automatic expect_now(input string req, input logic [11:0] d,
                              input logic p, input logic e);
        vectors++;
        if (dac_code !== d || shutdown !== p || frame_err !== e) begin
            errors++;
            $display("FAIL %s: dac=%h pd=%b err=%b expected dac=%h pd=%b err=%b",
                     req, dac_code, shutdown, frame_err, d, p, e);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // kind: 0 none, 1 load strobe, 2 clear, applied after bit spoil_at
    task automatic send_word(input logic [15:0] w, input int nbits,
                             input int spoil_at, input int kind);
        cs_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < nbits; i++) begin
            din = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
            if (i == spoil_at && kind != 0) begin
                if (kind == 1) ldac_n = 1'b0;
                else           clr_n  = 1'b0;
                wait_clk(3);
                ldac_n = 1'b1;
                clr_n  = 1'b1;
            end
        end
        wait_clk(3);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R12 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        expect_now("R13", 12'h000, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_clk(4);

        cur_req = "R2";
        send_word({4'b0001, 12'hA5C}, 16, -1, 0);
        expect_now("R2", 12'h000, 1'b0, 1'b0);
        cur_req = "R4";
        send_word({4'b0100, 12'hFFF}, 16, -1, 0);
        expect_now("R4", 12'hA5C, 1'b0, 1'b0);
        cur_req = "R3";
        send_word({4'b0010, 12'h123}, 16, -1, 0);
        expect_now("R3 R1", 12'h123, 1'b0, 1'b0);
        send_word({4'b0100, 12'h000}, 16, -1, 0);
        expect_now("R4", 12'h123, 1'b0, 1'b0);

        cur_req = "R7";
        send_word({4'b0001, 12'h7E1}, 16, -1, 0);
        expect_now("R2", 12'h123, 1'b0, 1'b0);
        ldac_n = 1'b0;
        wait_clk(3);
        expect_now("R12 early", 12'h123, 1'b0, 1'b0);
        wait_clk(1);
        expect_now("R12 on time", 12'h7E1, 1'b0, 1'b0);
        wait_clk(4);
        ldac_n = 1'b1;
        wait_clk(6);
        expect_now("R7", 12'h7E1, 1'b0, 1'b0);

        cur_req = "R5";
        send_word({4'b0110, 12'hABC}, 16, -1, 0);
        expect_now("R5 down", 12'h7E1, 1'b1, 1'b0);
        send_word({4'b1000, 12'hABC}, 16, -1, 0);
        expect_now("R5 up", 12'h7E1, 1'b0, 1'b0);

        cur_req = "R6";
        send_word({4'b0001, 12'h456}, 16, -1, 0);
        send_word({4'b0000, 12'hBBB}, 16, -1, 0);
        send_word({4'b0011, 12'hBBB}, 16, -1, 0);
        send_word({4'b0101, 12'hBBB}, 16, -1, 0);
        send_word({4'b1111, 12'hBBB}, 16, -1, 0);
        send_word({4'b1110, 12'hBBB}, 16, -1, 0);
        expect_now("R6 reserved", 12'h7E1, 1'b0, 1'b0);
        send_word({4'b0100, 12'h000}, 16, -1, 0);
        expect_now("R6 staging kept", 12'h456, 1'b0, 1'b0);

        cur_req = "R9";
        send_word({4'b0010, 12'h999}, 15, -1, 0);
        expect_now("R9 short", 12'h456, 1'b0, 1'b1);
        send_word({4'b0010, 12'h999}, 17, -1, 0);
        expect_now("R9 long", 12'h456, 1'b0, 1'b1);
        cur_req = "R11";
        send_word({4'b0000, 12'h000}, 16, -1, 0);
        expect_now("R11", 12'h456, 1'b0, 1'b0);

        cur_req = "R10";
        send_word({4'b0001, 12'h111}, 16, -1, 0);
        send_word({4'b0010, 12'h222}, 16, 5, 1);
        expect_now("R10 strobe", 12'h111, 1'b0, 1'b1);
        send_word({4'b0100, 12'h000}, 16, -1, 0);
        expect_now("R10 R11 staging kept", 12'h111, 1'b0, 1'b0);

        cur_req = "R8";
        send_word({4'b0010, 12'hABC}, 16, -1, 0);
        send_word({4'b0110, 12'h000}, 16, -1, 0);
        clr_n = 1'b0;
        wait_clk(6);
        expect_now("R8 clear", 12'h000, 1'b1, 1'b0);
        clr_n = 1'b1;
        wait_clk(6);
        send_word({4'b0100, 12'h000}, 16, -1, 0);
        expect_now("R8 staging zero", 12'h000, 1'b1, 1'b0);
        send_word({4'b1000, 12'h000}, 16, -1, 0);

        cur_req = "R10";
        send_word({4'b0010, 12'h5A5}, 16, -1, 0);
        expect_now("R3", 12'h5A5, 1'b0, 1'b0);
        send_word({4'b0001, 12'h333}, 16, 3, 2);
        expect_now("R10 clear", 12'h000, 1'b0, 1'b1);
        send_word({4'b0100, 12'h000}, 16, -1, 0);
        expect_now("R10 R8 staging", 12'h000, 1'b0, 1'b0);

        wait_clk(4);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule